// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block sits behind a test access port and gives a scan chain read and write access to the register file of a trace capture buffer. Each scan moves a 40-bit frame through a shift register, least significant bit first. The frame holds a 32-bit data field in bits 31:0, a 7-bit register address in bits 38:32 and a direction bit in bit 39. When the update strobe arrives, a frame with direction 1 becomes a one-cycle write strobe on the register bus, carrying the frame's address and data. A frame with direction 0 becomes a one-cycle read strobe, and the returned word is held until the next scan's capture phase. That phase loads the word into the low 32 bits of the shift register, so it leaves on the serial output during the next scan.

Reads are therefore pipelined by one scan: each scan returns what the previous scan addressed. Some addresses have read side effects. Address 4 is the trace RAM data port, and each read of it advances the RAM read pointer. Software ends a burst of RAM reads with a trailing read of address 0, the identification register, so that no trace entry is consumed without being returned. The port responds only while the instruction register holds the selection code (0xC by default). Addresses at or above the number of implemented registers are dropped: they raise no strobe and read as zero.

Top module: `scan_reg_port`

## Requirements
- R1: Serial order: while the port is selected and shift is high (capture low), the frame register moves one place toward bit 0 on each clock, with tdi entering bit 39. tdo shows bit 0. A frame is {direction bit 39, address bits 38:32, data bits 31:0}.
- R2: An update of a selected frame whose bit 39 is 1, addressing a defined register, gives exactly one cycle of bus_we in the cycle after the update edge, with bus_addr equal to the frame address and bus_wdata equal to the frame data.
- R3: An update of a selected frame whose bit 39 is 0, addressing a defined register, gives exactly one cycle of bus_re in the cycle after the update edge, with bus_addr equal to the frame address. No bus_we is raised.
- R4: A selected capture loads bits 31:0 of the frame register with the word read during the most recent read strobe and clears bits 39:32. The next scan's serial output therefore carries the data addressed by the previous scan.
- R5: After reset, and after any write update, the next capture loads an all-zero frame.
- R6: An address at or above NUM_REGS (9 by default) raises neither bus_we nor bus_re, and a read of such an address returns zero at the next capture.
- R7: When ir_code differs from SEL_CODE, capture, shift and update have no effect: tdo is 0, no bus strobe is raised, and the frame register keeps its value.
- R8: bus_we and bus_re are never high together, and each update produces at most one strobe. Two consecutive reads of address 4 therefore advance the RAM pointer exactly twice, and a trailing read of address 0 returns the second RAM word.
- R9: While rst_n is low, tdo, bus_we and bus_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current instruction register value |
| capture | input | 1 | Capture phase strobe |
| shift | input | 1 | Shift phase enable |
| update | input | 1 | Update phase strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_addr | output | 7 | Register address toward the buffer core |
| bus_wdata | output | 32 | Write data toward the buffer core |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data from the buffer core, valid while bus_re is high |

## Verification
The port is driven with complete scans. Each scan's output is checked against the target of the previous scan, which shows whether the block returns current data or data one scan late. The scan sequences include: a write followed by a read (a zero must come back), repeated reads of the RAM port ended by an identification read (to check that the pointer moves exactly once per read), and accesses to undefined addresses (to separate dropped strobes from zeroed data). A full scan made while the port is deselected, followed by a readback, shows whether a stray update reached the register file.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

   // Kind of access launched by the most recent update
   typedef enum logic [2:0] {
      ACC_NONE    = 3'd0,
      ACC_RD      = 3'd1,
      ACC_RD_NULL = 3'd2,
      ACC_WR      = 3'd3,
      ACC_WR_NULL = 3'd4
   } acc_e;

   localparam int DIR_WRITE = 1;

endpackage

// File: rtl/scan_shifter.sv
module scan_shifter #(
   parameter int FRAME_W = 40,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               capture,
   input  logic               shift,
   input  logic               tdi,
   input  logic [DATA_W-1:0]  load_data,
   output logic [FRAME_W-1:0] frame_q
);

   localparam int PAD_W = FRAME_W - DATA_W;

   generate
      if (PAD_W < 2) begin : g_bad_frame
         $error("scan_shifter: frame must exceed data width by at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (en) begin
         if (capture) begin
            frame_q <= {{PAD_W{1'b0}}, load_data};
         end else if (shift) begin
            frame_q <= {tdi, frame_q[FRAME_W-1:1]};
         end
      end
   end

endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
   import scan_port_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 7,
   parameter int NUM_REGS = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd,
   input  logic [DATA_W+ADDR_W:0]   frame_in,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [DATA_W-1:0]        bus_wdata,
   output logic                     bus_we,
   output logic                     bus_re,
   output acc_e                     acc_kind
);

   localparam int FRAME_W   = DATA_W + ADDR_W + 1;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] f_data;
   logic              f_dir;
   logic              addr_ok;

   assign f_data = frame_in[DATA_W-1:0];
   assign f_addr = frame_in[FRAME_W-2:DATA_W];
   assign f_dir  = frame_in[FRAME_W-1];

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("access_ctrl: NUM_REGS must be at least 1");
      end
      if (NUM_REGS >= ADDR_SPAN) begin : g_full_map
         assign addr_ok = 1'b1;
      end else begin : g_part_map
         localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);
         assign addr_ok = (f_addr < LIMIT);
      end
   endgenerate

   acc_e kind_d;

   always_comb begin
      kind_d = ACC_NONE;
      if (upd) begin
         if (f_dir == 1'(DIR_WRITE)) kind_d = addr_ok ? ACC_WR : ACC_WR_NULL;
         else                        kind_d = addr_ok ? ACC_RD : ACC_RD_NULL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_kind  <= ACC_NONE;
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_we    <= 1'b0;
         bus_re    <= 1'b0;
      end else begin
         acc_kind <= kind_d;
         bus_we   <= (kind_d == ACC_WR);
         bus_re   <= (kind_d == ACC_RD);
         if (upd) begin
            bus_addr  <= f_addr;
            bus_wdata <= f_data;
         end
      end
   end

endmodule

// File: rtl/read_holder.sv
module read_holder
   import scan_port_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc_kind,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] hold_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else begin
         case (acc_kind)
            ACC_RD:                          hold_q <= bus_rdata;
            ACC_RD_NULL, ACC_WR, ACC_WR_NULL: hold_q <= '0;
            default:                         hold_q <= hold_q;
         endcase
      end
   end

endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
   import scan_port_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 7,
   parameter int          NUM_REGS = 9,
   parameter int          IR_W     = 4,
   parameter logic [IR_W-1:0] SEL_CODE = 4'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IR_W-1:0]   ir_code,
   input  logic              capture,
   input  logic              shift,
   input  logic              update,
   input  logic              tdi,
   output logic              tdo,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam int FRAME_W = DATA_W + ADDR_W + 1;

   generate
      if (DATA_W < 1 || ADDR_W < 1 || IR_W < 1) begin : g_bad_width
         $error("scan_reg_port: widths must be positive");
      end
   endgenerate

   logic               sel;
   logic [FRAME_W-1:0] frame_q;
   logic [DATA_W-1:0]  hold_q;
   acc_e               acc_kind;

   assign sel = (ir_code == SEL_CODE);

   scan_shifter #(
      .FRAME_W (FRAME_W),
      .DATA_W  (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (sel),
      .capture   (capture),
      .shift     (shift),
      .tdi       (tdi),
      .load_data (hold_q),
      .frame_q   (frame_q)
   );

   access_ctrl #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (update & sel),
      .frame_in  (frame_q),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .acc_kind  (acc_kind)
   );

   read_holder #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_kind  (acc_kind),
      .bus_rdata (bus_rdata),
      .hold_q    (hold_q)
   );

   assign tdo = sel & frame_q[0];

endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk #(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 7,
   parameter int          NUM_REGS = 9,
   parameter int          IR_W     = 4,
   parameter logic [IR_W-1:0] SEL_CODE = 4'hC
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [IR_W-1:0]                 ir_code,
   input logic                            capture,
   input logic                            shift,
   input logic                            update,
   input logic                            tdo,
   input logic                            bus_we,
   input logic                            bus_re,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [DATA_W+ADDR_W:0]          frame_q,
   input logic [DATA_W-1:0]               hold_q
);

   localparam int FRAME_W = DATA_W + ADDR_W + 1;

   logic sel;
   assign sel = (ir_code == SEL_CODE);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   p_we_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> $past(update && sel && frame_q[FRAME_W-1]));

   p_re_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |-> $past(update && sel && !frame_q[FRAME_W-1]));

   p_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we || bus_re) |-> ({1'b0, bus_addr} < (ADDR_W+1)'(NUM_REGS)));

   p_tdo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !tdo);

   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(frame_q));

   p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shift && !capture) |=>
         (frame_q[FRAME_W-2:0] == $past(frame_q[FRAME_W-1:1])));

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && capture) |=>
         (frame_q == {{(ADDR_W+1){1'b0}}, $past(hold_q)}));

   always_comb begin
      if (!rst_n) begin
         a_reset_r9: assert (!bus_we && !bus_re);
      end
   end

endmodule

bind scan_reg_port scan_reg_port_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS),
   .IR_W     (IR_W),
   .SEL_CODE (SEL_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ir_code  (ir_code),
   .capture  (capture),
   .shift    (shift),
   .update   (update),
   .tdo      (tdo),
   .bus_we   (bus_we),
   .bus_re   (bus_re),
   .bus_addr (bus_addr),
   .frame_q  (frame_q),
   .hold_q   (hold_q)
);

// File: tb/scan_reg_port_bench.sv
`timescale 1ns/1ps
module scan_reg_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ir_code = 4'hC;
   logic        capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
   logic        tdo;
   logic [6:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        bus_we, bus_re;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int we_cnt = 0;
   int re_cnt = 0;

   always #2 clk = ~clk;

   scan_reg_port u_scan_reg_port (
      .clk(clk), .rst_n(rst_n), .ir_code(ir_code),
      .capture(capture), .shift(shift), .update(update),
      .tdi(tdi), .tdo(tdo),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
   );

   // Register file stand-in: 0 = identity, 4 = RAM port, others plain storage
   localparam logic [31:0] ID_VAL = 32'h4A5B_0001;
   logic [31:0] regs [0:8];
   int ram_ptr = 0;

   function automatic logic [31:0] rf_val(input logic [6:0] a);
      if (a == 7'd0)      return ID_VAL;
      else if (a == 7'd4) return 32'hD000_0000 | 32'(ram_ptr);
      else if (a < 7'd9)  return regs[a[3:0]];
      else                return 32'hDEAD_BEEF;
   endfunction

   always_comb bus_rdata = rf_val(bus_addr);

   always @(posedge clk) begin
      if (bus_we && bus_addr < 7'd9 && bus_addr != 7'd0 && bus_addr != 7'd4)
         regs[bus_addr[3:0]] <= bus_wdata;
      if (bus_re && bus_addr == 7'd4) ram_ptr <= ram_ptr + 1;
      if (bus_we) we_cnt <= we_cnt + 1;
      if (bus_re) re_cnt <= re_cnt + 1;
   end

   // Behavioural reference model
   logic [39:0] m_sr;
   logic [31:0] m_hold, m_wdata;
   logic [6:0]  m_addr;
   logic        m_we, m_re, m_zero;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sr <= '0; m_hold <= '0; m_wdata <= '0; m_addr <= '0;
         m_we <= 0; m_re <= 0; m_zero <= 0;
      end else begin
         if (m_re)   m_hold <= rf_val(m_addr);
         if (m_zero) m_hold <= '0;
         m_we <= 0; m_re <= 0; m_zero <= 0;
         if (ir_code == 4'hC) begin
            if (capture)    m_sr <= {8'h00, m_hold};
            else if (shift) m_sr <= {tdi, m_sr[39:1]};
            if (update) begin
               m_addr  <= m_sr[38:32];
               m_wdata <= m_sr[31:0];
               if (m_sr[38:32] < 7'd9) begin
                  m_we   <= m_sr[39];
                  m_re   <= !m_sr[39];
                  m_zero <= m_sr[39];
               end else begin
                  m_zero <= 1'b1;
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      #0.5;
      if (rst_n) begin
         check(tdo == ((ir_code == 4'hC) ? m_sr[0] : 1'b0), "R1/R7", "tdo",
               32'(tdo), 32'((ir_code == 4'hC) ? m_sr[0] : 1'b0));
         check(bus_we == m_we, "R2/R6", "bus_we", 32'(bus_we), 32'(m_we));
         check(bus_re == m_re, "R3/R6", "bus_re", 32'(bus_re), 32'(m_re));
         if (m_we || m_re)
            check(bus_addr == m_addr, "R2/R3", "bus_addr", 32'(bus_addr), 32'(m_addr));
         if (m_we)
            check(bus_wdata == m_wdata, "R2", "bus_wdata", bus_wdata, m_wdata);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic scan(input bit dir, input logic [6:0] a, input logic [31:0] d,
                       output logic [31:0] got);
      logic [39:0] f;
      logic [39:0] o;
      f = {dir, a, d};
      @(negedge clk) capture = 1'b1;
      @(negedge clk) capture = 1'b0; shift = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tdi = f[i];
         o[i] = tdo;
         @(negedge clk);
      end
      shift = 1'b0; tdi = 1'b0; update = 1'b1;
      @(negedge clk) update = 1'b0;
      @(negedge clk);
      @(negedge clk);
      got = o[31:0];
      check(o[39:32] == 8'h00, "R4", "captured upper bits", 32'(o[39:32]), 32'h0);
   endtask

   initial begin
      logic [31:0] got;
      int we0, re0;
      for (int k = 0; k < 9; k++) regs[k] = 32'h0;
      repeat (3) @(negedge clk);
      #0.5;
      check(!tdo && !bus_we && !bus_re, "R9", "outputs in reset",
            {29'b0, tdo, bus_we, bus_re}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R5: first scan after reset returns zero; R2: write reg 2
      we0 = we_cnt;
      scan(1'b1, 7'd2, 32'h1234_5678, got);
      check(got == 32'h0, "R5", "first scan after reset", got, 32'h0);
      check(we_cnt == we0 + 1, "R2", "write strobe count", 32'(we_cnt - we0), 32'd1);

      // R3/R5: read after a write gives zero
      re0 = re_cnt;
      scan(1'b0, 7'd2, 32'h0, got);
      check(got == 32'h0, "R5", "scan after write", got, 32'h0);
      check(re_cnt == re0 + 1, "R3", "read strobe count", 32'(re_cnt - re0), 32'd1);

      // R4: pipelined read result
      scan(1'b0, 7'd0, 32'h0, got);
      check(got == 32'h1234_5678, "R4", "reg2 readback", got, 32'h1234_5678);

      // R8: two RAM reads and trailing identity read
      scan(1'b0, 7'd4, 32'h0, got);
      check(got == ID_VAL, "R4", "identity readback", got, ID_VAL);
      scan(1'b0, 7'd4, 32'h0, got);
      check(got == 32'hD000_0000, "R8", "first RAM word", got, 32'hD000_0000);
      scan(1'b0, 7'd0, 32'h0, got);
      check(got == 32'hD000_0001, "R8", "second RAM word", got, 32'hD000_0001);
      check(ram_ptr == 2, "R8", "RAM pointer advance", 32'(ram_ptr), 32'd2);

      // R6: undefined address read and write
      re0 = re_cnt;
      scan(1'b0, 7'h50, 32'h0, got);
      check(re_cnt == re0, "R6", "no read strobe for undefined", 32'(re_cnt - re0), 32'd0);
      we0 = we_cnt;
      scan(1'b1, 7'd9, 32'hFFFF_0000, got);
      check(got == 32'h0, "R6", "undefined read value", got, 32'h0);
      check(we_cnt == we0, "R6", "no write strobe for undefined", 32'(we_cnt - we0), 32'd0);

      // R7: deselected port ignores a full write scan
      ir_code = 4'h3;
      we0 = we_cnt;
      scan(1'b1, 7'd2, 32'hFFFF_FFFF, got);
      check(got == 32'h0, "R7", "tdo while deselected", got, 32'h0);
      check(we_cnt == we0, "R7", "no strobe while deselected", 32'(we_cnt - we0), 32'd0);
      ir_code = 4'hC;
      scan(1'b0, 7'd2, 32'h0, got);
      scan(1'b0, 7'd0, 32'h0, got);
      check(got == 32'h1234_5678, "R7", "reg2 untouched", got, 32'h1234_5678);

      // R1: bit ordering with an asymmetric pattern
      scan(1'b1, 7'd3, 32'hA5A5_0F0F, got);
      scan(1'b0, 7'd3, 32'h0, got);
      scan(1'b0, 7'd0, 32'h0, got);
      check(got == 32'hA5A5_0F0F, "R1", "reg3 pattern", got, 32'hA5A5_0F0F);

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule